// File: doc/BRIEF.md
# Edge-Latched Bytewide Memory Core

This block is a clock-sampled model of a byte-wide memory array that sits behind an asynchronous-style parallel bus with three active-low controls: chip select (`ce_n`), write strobe (`we_n`) and output strobe (`oe_n`). A fast system clock samples every bus pin. The first clock edge that sees `ce_n` low after it was high is the start edge of a memory cycle. At that edge the address is captured, and later address movement has no effect. Each cycle then runs an internal access of fixed length, counted in clock edges. The data bus is only released onto the output once that access has finished.

A cycle is a read unless the write strobe is involved. If `we_n` is already low at the start edge, the cycle is a write from the start and never drives the bus. If `we_n` drops later, the cycle begins as a read and turns into a write at that point. The byte is stored on the first sampled rise of either `we_n` or `ce_n`. Between cycles, chip select must stay high for a minimum number of samples. A select edge that comes too early is refused and recorded in a sticky flag. A second sticky flag records a select pulse held low for too long. The bidirectional data bus appears as a separate input, a separate output and a drive-enable. The array depth is set by `ADDR_W`; the full device uses 15 bits, and the default is smaller so that elaboration stays light.

Top module: `bytewide_mem`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dout_en` is 0, `dout` is 0 and both flags are 0. The precharge is treated as already met, so the first select edge after reset starts a cycle. Reset does not clear the array contents.
- R2: The address is captured at the start edge only. Address changes later in that cycle do not change which byte is read or written.
- R3: In a read cycle, `dout_en` is 1 exactly when the access is complete, `ce_n` is 0, `oe_n` is 0 and `we_n` is 1. In that state `dout` carries the byte at the captured address. Whenever `dout_en` is 0, `dout` is 0.
- R4: The access completes after the T_ACC-th clock edge that follows the start edge. With `oe_n` low from the start, `dout_en` is still 0 after edge T_ACC-1 and becomes 1 after edge T_ACC. If `oe_n` falls later than that, the drive starts as soon as `oe_n` is low.
- R5: If `we_n` is 0 at the start edge, `dout_en` stays 0 for the whole cycle whatever `oe_n` does. The stored byte is the `din` sampled at the first edge that sees `ce_n` or `we_n` high.
- R6: If `we_n` falls during a read cycle, `dout_en` drops at once and stays 0 for the rest of the cycle. The byte stored is the `din` sampled at the edge that first sees `we_n` high again. A later rise of `ce_n` in the same cycle stores nothing more.
- R7: An internal cycle runs to the end of its access even if `ce_n` rises early. A select edge that arrives before that cycle has finished is refused: no cycle starts, nothing is driven, and `pre_viol` is set.
- R8: A select edge starts a cycle only after at least T_PRE consecutive samples of `ce_n` high. An earlier select edge is refused: the address is not captured, nothing is written, and `pre_viol` is set and stays 1 until reset.
- R9: `ce_long` is set when `ce_n` has been sampled low on more than T_CE_MAX consecutive edges, and stays 1 until reset.
- R10: When `ce_n` goes high, `dout_en` falls immediately and the bus returns to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | ADDR_W | Byte address, captured at the start edge |
| din | input | DATA_W | Write data side of the data bus |
| dout | output | DATA_W | Read data side of the data bus, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |
| pre_viol | output | 1 | Sticky: a select edge was refused |
| ce_long | output | 1 | Sticky: chip select was held low too long |

## Verification
The bound checker looks at a set of properties on every cycle. It checks that the captured address holds steady while a cycle is in progress, that the bus is never driven on the edge after a start, and that a write-from-start cycle is quiet on its first edge. It also checks that a commit only happens inside a live cycle, that two starts never come back to back, that a drive only begins during a cycle that is already running, and that both flags are sticky. Some behaviour can only be seen from the bench's scenarios. These are which byte lands where, the exact edge on which the drive starts, the `din` sample taken at the end of a write, refused edges that leave the array untouched, and the exact edge counts at the precharge and low-time limits. The bench sweeps every address with both write styles and reads each byte back against an arithmetic pattern.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // Saturating increment toward a limit.
  function automatic logic [31:0] sat_up(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // True when a count has reached its limit.
  function automatic logic reached(input logic [31:0] v, input logic [31:0] lim);
    return v >= lim;
  endfunction

  // High-to-low transition between two successive samples of an active-low pin.
  function automatic logic went_low(input logic prev_n, input logic now_n);
    return prev_n & ~now_n;
  endfunction
endpackage

// File: rtl/nvm_bus_watch.sv
module nvm_bus_watch
  import nvm_pkg::*;
#(
  parameter int T_PRE    = 3,
  parameter int T_CE_MAX = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cyc_busy,
  output logic cyc_start,
  output logic pre_viol,
  output logic ce_long
);
  localparam int PW = $clog2(T_PRE + 1) < 1 ? 1 : $clog2(T_PRE + 1);
  localparam int LW = $clog2(T_CE_MAX + 2);

  logic          ce_q;
  logic [PW-1:0] pre_cnt;
  logic [LW-1:0] low_cnt;
  logic          sel_edge;
  logic          pre_met;

  assign sel_edge  = went_low(ce_q, ce_n);
  assign pre_met   = reached(32'(pre_cnt), T_PRE);
  assign cyc_start = sel_edge & pre_met & ~cyc_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      pre_cnt  <= PW'(T_PRE);
      low_cnt  <= '0;
      pre_viol <= 1'b0;
      ce_long  <= 1'b0;
    end else begin
      ce_q    <= ce_n;
      pre_cnt <= ce_n ? PW'(sat_up(32'(pre_cnt), T_PRE)) : '0;
      low_cnt <= ce_n ? '0 : LW'(sat_up(32'(low_cnt), T_CE_MAX + 1));
      if (sel_edge && !cyc_start)
        pre_viol <= 1'b1;
      if (!ce_n && reached(32'(low_cnt), T_CE_MAX))
        ce_long <= 1'b1;
    end
  end
endmodule

// File: rtl/nvm_cycle_seq.sv
module nvm_cycle_seq
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int T_ACC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              acc_ready,
  output logic              wr_commit,
  output logic              drive
);
  localparam int AW = $clog2(T_ACC + 1) < 1 ? 1 : $clog2(T_ACC + 1);

  logic [AW-1:0] acc_cnt;
  logic          open_q;   // select still low since the start edge
  logic          wr_mode;  // cycle has become a write
  logic          armed;    // a write is pending its closing edge
  logic          we_hit;

  assign acc_ready = busy & reached(32'(acc_cnt), T_ACC);
  assign wr_commit = armed & (we_n | ce_n);
  assign we_hit    = open_q & ~ce_n & ~we_n;
  assign drive     = acc_ready & open_q & ~ce_n & ~oe_n & we_n & ~wr_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      acc_cnt  <= '0;
      open_q   <= 1'b0;
      wr_mode  <= 1'b0;
      armed    <= 1'b0;
      lat_addr <= '0;
    end else if (cyc_start) begin
      busy     <= 1'b1;
      acc_cnt  <= '0;
      open_q   <= 1'b1;
      wr_mode  <= ~we_n;
      armed    <= ~we_n;
      lat_addr <= addr;
    end else begin
      if (busy)
        acc_cnt <= AW'(sat_up(32'(acc_cnt), T_ACC));
      if (acc_ready && ce_n)
        busy <= 1'b0;
      if (ce_n)
        open_q <= 1'b0;
      if (wr_commit)
        armed <= 1'b0;
      else if (we_hit)
        armed <= 1'b1;
      if (we_hit)
        wr_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wen)
      cells[idx] <= wdata;
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/bytewide_mem.sv
module bytewide_mem #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int T_ACC    = 4,
  parameter int T_PRE    = 3,
  parameter int T_CE_MAX = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              pre_viol,
  output logic              ce_long
);
  // Named internal events, visible to the bound checker.
  logic              cyc_start;
  logic              busy;
  logic              acc_ready;
  logic              wr_commit;
  logic              drive;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] rdata;

  nvm_bus_watch #(.T_PRE(T_PRE), .T_CE_MAX(T_CE_MAX)) u_watch (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cyc_busy(busy),
    .cyc_start(cyc_start), .pre_viol(pre_viol), .ce_long(ce_long)
  );

  nvm_cycle_seq #(.ADDR_W(ADDR_W), .T_ACC(T_ACC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .busy(busy), .lat_addr(lat_addr), .acc_ready(acc_ready),
    .wr_commit(wr_commit), .drive(drive)
  );

  nvm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wen(wr_commit), .idx(lat_addr), .wdata(din), .rdata(rdata)
  );

  assign dout_en = drive;
  assign dout    = drive ? rdata : '0;
endmodule

// File: rtl/nvm_core_chk.sv
module nvm_core_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we_n,
  input logic              dout_en,
  input logic              pre_viol,
  input logic              ce_long,
  input logic              cyc_start,
  input logic              busy,
  input logic              acc_ready,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] lat_addr
);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_start) |=> $stable(lat_addr));

  // R4
  no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !dout_en);

  // R4
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && !cyc_start) |=> (acc_ready || !busy));

  // R5
  write_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !we_n) |=> !dout_en);

  // R6
  commit_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> busy);

  // R3
  drive_in_live_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> ($past(busy) && !cyc_start));

  // R8
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);

  // R8
  pre_viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_viol |=> pre_viol);

  // R9
  ce_long_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_long |=> ce_long);
endmodule

bind bytewide_mem nvm_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .dout_en(dout_en),
  .pre_viol(pre_viol), .ce_long(ce_long), .cyc_start(cyc_start),
  .busy(busy), .acc_ready(acc_ready), .wr_commit(wr_commit),
  .lat_addr(lat_addr)
);

// File: tb/tb_bytewide_mem.sv
`timescale 1ns/1ps
module tb_bytewide_mem;
  localparam int AW   = 6;
  localparam int ACC  = 4;
  localparam int PRE  = 3;
  localparam int CMAX = 40;
  localparam int N    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en, pre_viol, ce_long;

  logic [7:0] exp_mem [N];
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  bytewide_mem #(.ADDR_W(AW), .DATA_W(8), .T_ACC(ACC), .T_PRE(PRE), .T_CE_MAX(CMAX)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .pre_viol(pre_viol), .ce_long(ce_long)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + salt * 91 + 11) & 255);
  endfunction

  task automatic do_reset();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; rst_n = 1'b0;
    repeat (3) step();
    chk(dout_en == 1'b0 && dout == 8'h00, "R1", "bus quiet in reset", {dout_en, dout}, 0);
    chk(pre_viol == 1'b0 && ce_long == 1'b0, "R1", "flags clear in reset", {pre_viol, ce_long}, 0);
    rst_n = 1'b1;
    step();
    chk(dout_en == 1'b0 && pre_viol == 1'b0 && ce_long == 1'b0, "R1", "quiet after reset",
        {dout_en, pre_viol, ce_long}, 0);
  endtask

  // Write with the write strobe low at the select edge; din only valid at the end.
  task automatic ce_write(input int a, input logic [7:0] d);
    addr = AW'(a); we_n = 1'b0; oe_n = 1'b0; din = ~d; ce_n = 1'b0;
    step();
    addr = ~AW'(a);
    for (int i = 0; i < ACC; i++) begin
      step();
      chk(dout_en == 1'b0, "R5", "no drive in select-led write", dout_en, 0);
    end
    din = d; ce_n = 1'b1; we_n = 1'b1;
    step();
    exp_mem[a] = d;
    din = 8'h00;
    repeat (PRE - 1) step();
  endtask

  // Read with oe low from the start; checks the drive edge and the data.
  task automatic rd(input int a);
    addr = AW'(a); we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    step();
    addr = AW'(a) ^ AW'(42);
    repeat (ACC - 1) step();
    chk(dout_en == 1'b0 && dout == 8'h00, "R4", "no drive before access time", {dout_en, dout}, 0);
    step();
    chk(dout_en == 1'b1, "R4", "drive at access time", dout_en, 1);
    chk(dout == exp_mem[a], "R3", "read data (R2 latched addr)", dout, exp_mem[a]);
    ce_n = 1'b1;
    #1;
    chk(dout_en == 1'b0 && dout == 8'h00, "R10", "standby after select rise", {dout_en, dout}, 0);
    repeat (PRE) step();
  endtask

  // Write that starts as a read and turns into a write when we_n falls.
  task automatic we_write(input int a, input logic [7:0] d);
    addr = AW'(a); we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0; din = 8'h00;
    step();
    addr = ~AW'(a);
    repeat (ACC) step();
    chk(dout_en == 1'b1 && dout == exp_mem[a], "R6", "read phase drives old byte", dout, exp_mem[a]);
    we_n = 1'b0; din = ~d;
    #1;
    chk(dout_en == 1'b0, "R6", "drive drops when we_n falls", dout_en, 0);
    step();
    din = d; we_n = 1'b1;
    step();
    chk(dout_en == 1'b0, "R6", "no drive after write phase", dout_en, 0);
    din = ~d;
    step();
    ce_n = 1'b1;
    step();
    exp_mem[a] = d;
    din = 8'h00;
    repeat (PRE - 1) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // R5 sweep: every address written with the select-led style.
    for (int a = 0; a < N; a++) ce_write(a, pat(a, 0));
    for (int a = 0; a < N; a++) rd(a);

    // R6 sweep: every address rewritten with the strobe-led style.
    for (int a = N - 1; a >= 0; a--) we_write(a, pat(a, 1));
    for (int a = 0; a < N; a++) rd(a);
    chk(pre_viol == 1'b0, "R8", "exact precharge accepted", pre_viol, 0);

    // R4: output strobe arriving after the access time.
    addr = AW'(17); we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    repeat (ACC + 3) step();
    chk(dout_en == 1'b0, "R3", "no drive with oe_n high", dout_en, 0);
    oe_n = 1'b0;
    #1;
    chk(dout_en == 1'b1 && dout == exp_mem[17], "R4", "late oe drives at once", dout, exp_mem[17]);
    ce_n = 1'b1;
    repeat (PRE) step();

    // R7: select rises early, falls again before the cycle ends.
    addr = AW'(3); we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    step();
    ce_n = 1'b1;
    repeat (PRE) step();
    addr = AW'(9); ce_n = 1'b0;
    step();
    chk(pre_viol == 1'b1, "R7", "refused edge during running cycle", pre_viol, 1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk(dout_en == 1'b0, "R7", "refused edge never drives", dout_en, 0);
    end
    ce_n = 1'b1;
    repeat (PRE) step();
    rd(9);

    // R1 + R8: after reset an immediate edge is accepted; a short precharge is refused.
    do_reset();
    rd(20);
    addr = AW'(20); we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    repeat (ACC + 1) step();
    ce_n = 1'b1;
    repeat (PRE - 1) step();
    chk(pre_viol == 1'b0, "R8", "flag clear before short gap", pre_viol, 0);
    addr = AW'(12); we_n = 1'b0; din = ~exp_mem[12]; ce_n = 1'b0;
    step();
    chk(pre_viol == 1'b1, "R8", "short precharge flagged", pre_viol, 1);
    repeat (3) step();
    ce_n = 1'b1; we_n = 1'b1;
    repeat (PRE) step();
    rd(12);
    chk(pre_viol == 1'b1, "R8", "flag sticky", pre_viol, 1);

    // R9: select held low past the limit.
    do_reset();
    addr = AW'(0); we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    repeat (CMAX) step();
    chk(ce_long == 1'b0, "R9", "at limit not flagged", ce_long, 0);
    step();
    chk(ce_long == 1'b1, "R9", "beyond limit flagged", ce_long, 1);
    ce_n = 1'b1;
    repeat (PRE + 2) step();
    chk(ce_long == 1'b1 && pre_viol == 1'b0, "R9", "flag sticky, other flag clear",
        {ce_long, pre_viol}, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule